// File: doc/BRIEF.md
# Cross-Domain Pulse Transfer Synchronizer

This block carries single events from one clock domain into another, unrelated clock domain. In the source domain, a rising edge on `src_pulse_i` marks one event, however many source cycles the input then stays high. In the destination domain, each event appears as `dst_pulse_o` held high for exactly one destination clock cycle. The two clocks may have any ratio, and their phase relation does not matter.

In the source domain, an edge detector flips a single toggle bit once per detected rising edge. That bit is the only signal that crosses between domains. A parameterized chain of destination flops synchronizes it. One history flop follows the chain, and an XOR of the chain output with that flop marks each toggle change. The output is either that XOR directly or the XOR passed through one more flop. Each domain has its own active-low asynchronous reset, and the resets can be left out of the build. Back-to-back events are guaranteed only when the low time between two source pulses is at least twice the longer of the two clock periods. To reach a fully defined state, both resets must be held low together for at least `(SyncDepth+2)` destination periods plus two source periods. While a reset is low, the input should stay still. When resets are left out, the input must always be driven to a defined value, because nothing can clear an unknown state.

Top module: `cdc_pulse_xfer`

## Requirements
- R1: Only a low-to-high change of `src_pulse_i`, sampled on `src_clk_i`, starts a transfer. An input held high or held low for any number of source cycles starts nothing further.
- R2: Every transfer drives `dst_pulse_o` high for exactly one destination cycle, and that cycle is followed by a low cycle.
- R3: `SyncDepth` sets the number of destination synchronizer stages. Its legal range is 2 to 10, its default is 4, and values outside the range are clamped. With `RegOut` = 0, number the destination rising edges from 1, starting with the first edge after the source edge that sampled the rising input. The output goes high at edge number `SyncDepth`.
- R4: Pulses whose low gap is at least twice the longer clock period each produce their own output pulse.
- R5: A source pulse of any width, from a single source cycle upward, produces exactly one output pulse.
- R6: `RegOut` = 1 adds one destination flop, so the output goes high at edge number `SyncDepth+1`. `RegOut` = 0 takes the output combinationally from the last synchronizer stage and the history flop.
- R7: With `RstEn` = 1, `src_rst_ni` and `dst_rst_ni` are active-low and asynchronous, and each clears all state in its own domain. The output is low while reset is held. A transfer still in flight when both resets are asserted together produces no output after release.
- R8: After both resets are released, transfers resume with the same one-pulse-per-edge behaviour.
- R9: The behaviour holds with the destination clock either slower or faster than the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source clock |
| src_rst_ni | input | 1 | Source-domain reset, active low, asynchronous (ignored when `RstEn` = 0) |
| src_pulse_i | input | 1 | Event input; a rising edge requests one transfer |
| dst_clk_i | input | 1 | Destination clock |
| dst_rst_ni | input | 1 | Destination-domain reset, active low, asynchronous (ignored when `RstEn` = 0) |
| dst_pulse_o | output | 1 | One-cycle event pulse in the destination domain |

## Verification
The bench targets these corner cases:

- **Long pulses (R1).** A source pulse held high for many cycles must give one output pulse. A level-sensitive design would give a train of pulses.
- **Single-cycle and minimum-gap pulses (R4, R5).** Edge handling that is too slow would swallow or merge these events.
- **Latency (R3, R6).** Two instances with different depths and output modes are compared edge by edge against a behavioural latency model. This catches a stage too many or too few, and a swapped output mode.
- **Reset mid-transfer (R7, R8).** Both resets are asserted while an event is in flight. Stale state would emit a spurious pulse after release, and a stuck toggle would lose the next event.
- **Clock ratios (R9).** The whole sequence runs with the destination clock both slower and faster than the source clock.

// File: rtl/cdc_pulse_pkg.sv
package cdc_pulse_pkg;

  localparam int unsigned SYNC_DEPTH_MIN = 2;
  localparam int unsigned SYNC_DEPTH_MAX = 10;

  function automatic int unsigned clamp_depth(input int unsigned depth);
    if (depth < SYNC_DEPTH_MIN) return SYNC_DEPTH_MIN;
    if (depth > SYNC_DEPTH_MAX) return SYNC_DEPTH_MAX;
    return depth;
  endfunction

endpackage

// File: rtl/cdc_pulse_reg.sv
module cdc_pulse_reg #(
  parameter int unsigned Width = 1,
  parameter bit          RstEn = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Width-1:0] d_i,
  output logic [Width-1:0] q_o
);

  if (RstEn) begin : g_arst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_nrst
    logic unused_rst;
    assign unused_rst = rst_ni;
    always_ff @(posedge clk_i) q_o <= d_i;
  end

endmodule

// File: rtl/cdc_pulse_src.sv
module cdc_pulse_src #(
  parameter bit RstEn = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic tgl_o
);

  // st[0]: last sampled input, st[1]: event toggle
  logic [1:0] st_d, st_q;
  logic       rise;

  assign rise = pulse_i & ~st_q[0];
  assign st_d = {st_q[1] ^ rise, pulse_i};

  cdc_pulse_reg #(.Width(2), .RstEn(RstEn)) u_st (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (st_d),
    .q_o   (st_q)
  );

  assign tgl_o = st_q[1];

  p_level_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && st_q[0]) |=> $stable(tgl_o));

  p_level_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(tgl_o));

endmodule

// File: rtl/cdc_pulse_sync.sv
module cdc_pulse_sync #(
  parameter int unsigned Depth = 4,
  parameter bit          RstEn = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic hist_o
);

  // Depth sync stages plus one history stage
  logic [Depth:0] chain_q;

  for (genvar i = 0; i <= Depth; i++) begin : g_stage
    logic stage_d;
    if (i == 0) begin : g_head
      assign stage_d = d_i;
    end else begin : g_body
      assign stage_d = chain_q[i-1];
    end
    cdc_pulse_reg #(.Width(1), .RstEn(RstEn)) u_ff (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (stage_d),
      .q_o   (chain_q[i])
    );
  end

  assign q_o    = chain_q[Depth-1];
  assign hist_o = chain_q[Depth];

  p_hist_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o != hist_o) |=> (hist_o == $past(q_o)));

endmodule

// File: rtl/cdc_pulse_dst.sv
module cdc_pulse_dst #(
  parameter bit RegOut = 1'b0,
  parameter bit RstEn  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic hist_i,
  output logic pulse_o
);

  logic pulse_c;
  assign pulse_c = sync_i ^ hist_i;

  if (RegOut) begin : g_reg
    cdc_pulse_reg #(.Width(1), .RstEn(RstEn)) u_out (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pulse_c),
      .q_o   (pulse_o)
    );
  end else begin : g_comb
    assign pulse_o = pulse_c;
  end

  p_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_quiet_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pulse_o);

endmodule

// File: rtl/cdc_pulse_xfer.sv
module cdc_pulse_xfer #(
  parameter int unsigned SyncDepth = 4,
  parameter bit          RegOut    = 1'b0,
  parameter bit          RstEn     = 1'b1
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_pulse_i,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_pulse_o
);

  localparam int unsigned Depth = cdc_pulse_pkg::clamp_depth(SyncDepth);

  logic src_tgl;
  logic dst_sync, dst_hist;

  cdc_pulse_src #(.RstEn(RstEn)) u_src (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .pulse_i(src_pulse_i),
    .tgl_o  (src_tgl)
  );

  cdc_pulse_sync #(.Depth(Depth), .RstEn(RstEn)) u_sync (
    .clk_i (dst_clk_i),
    .rst_ni(dst_rst_ni),
    .d_i   (src_tgl),
    .q_o   (dst_sync),
    .hist_o(dst_hist)
  );

  cdc_pulse_dst #(.RegOut(RegOut), .RstEn(RstEn)) u_dst (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .sync_i (dst_sync),
    .hist_i (dst_hist),
    .pulse_o(dst_pulse_o)
  );

endmodule

// File: tb/tb_cdc_pulse_xfer.sv
`timescale 1ns/1ps
module tb_cdc_pulse_xfer;

  localparam int D0 = 4, G0 = 0;  // dut: depth 4, combinational out
  localparam int D1 = 2, G1 = 1;  // dut_reg: depth 2, registered out

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic out0, out1;

  realtime dhalf = 3.5;
  realtime hcur;
  int checks = 0, fails = 0;
  int dcount = 0;
  int n_out0 = 0, n_out1 = 0;
  bit prev_in = 1'b0, prev0 = 1'b0, prev1 = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R7";
  realtime evq[$];
  int dq0[$], dq1[$];

  cdc_pulse_xfer #(.SyncDepth(D0), .RegOut(G0), .RstEn(1'b1)) dut (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_pulse_i(src_pulse),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_pulse_o(out0));

  cdc_pulse_xfer #(.SyncDepth(D1), .RegOut(G1), .RstEn(1'b1)) dut_reg (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_pulse_i(src_pulse),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_pulse_o(out1));

  // 200 MHz source clock
  always #2.5 src_clk = ~src_clk;

  initial begin
    #0.2;
    forever begin
      hcur = dhalf;
      #hcur dst_clk = 1'b1;
      #hcur dst_clk = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source-side model: record rising-edge events
  always @(posedge src_clk) begin
    if (!src_rst_n) prev_in = 1'b0;
    else begin
      if (src_pulse && !prev_in) evq.push_back($realtime);
      prev_in = src_pulse;
    end
  end

  // destination-side model: latency from first capturing edge
  always @(posedge dst_clk) begin
    dcount++;
    if (dst_rst_n) begin
      while (evq.size() > 0 && evq[0] < $realtime) begin
        void'(evq.pop_front());
        dq0.push_back(dcount + D0 - 1 + G0);
        dq1.push_back(dcount + D1 - 1 + G1);
      end
    end
  end

  // compare every destination cycle, away from the edge
  always @(negedge dst_clk) begin
    if (!finished) begin
      bit e0, e1;
      e0 = (dq0.size() > 0 && dq0[0] == dcount);
      e1 = (dq1.size() > 0 && dq1[0] == dcount);
      if (e0) void'(dq0.pop_front());
      if (e1) void'(dq1.pop_front());
      chk({cur_req, "/R3 dut"}, int'(out0), int'(e0));
      chk({cur_req, "/R6 dut_reg"}, int'(out1), int'(e1));
      if (out0) begin chk("R2 dut width", int'(prev0), 0); n_out0++; end
      if (out1) begin chk("R2 dut_reg width", int'(prev1), 0); n_out1++; end
      prev0 = out0;
      prev1 = out1;
    end
  end

  task automatic send(input int width, input int gap);
    src_pulse = 1'b1;
    repeat (width) @(negedge src_clk);
    src_pulse = 1'b0;
    repeat (gap) @(negedge src_clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge src_clk);
  endtask

  task automatic do_reset(input int n);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    evq.delete();
    dq0.delete();
    dq1.delete();
    idle(n);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
  endtask

  task automatic phase_checks(input string req, input int b0, input int b1, input int n);
    chk({req, " dut count"}, n_out0 - b0, n);
    chk({req, " dut_reg count"}, n_out1 - b1, n);
  endtask

  initial begin
    int b0, b1;
    @(negedge src_clk);
    // R7: reset state
    cur_req = "R7";
    idle(4);
    chk("R7 dut reset out", int'(out0), 0);
    chk("R7 dut_reg reset out", int'(out1), 0);
    idle(16);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    idle(10);

    // R1: long high pulse gives one event
    cur_req = "R1";
    b0 = n_out0; b1 = n_out1;
    send(25, 30);
    phase_checks("R1", b0, b1, 1);

    // R5: widths including a single source cycle
    cur_req = "R5";
    b0 = n_out0; b1 = n_out1;
    send(1, 30); send(2, 30); send(3, 30); send(7, 30);
    phase_checks("R5", b0, b1, 4);

    // R4: minimum gap (3 src cycles >= 2 x 7 ns)
    cur_req = "R4";
    b0 = n_out0; b1 = n_out1;
    for (int i = 0; i < 6; i++) send(1 + (i % 3), 3);
    idle(30);
    phase_checks("R4", b0, b1, 6);

    // R7: reset with a transfer in flight drops it
    cur_req = "R7";
    b0 = n_out0; b1 = n_out1;
    src_pulse = 1'b1;
    @(negedge src_clk);
    src_pulse = 1'b0;
    @(posedge dst_clk);
    @(negedge src_clk);
    do_reset(20);
    idle(30);
    phase_checks("R7", b0, b1, 0);

    // R8: transfers resume after reset
    cur_req = "R8";
    b0 = n_out0; b1 = n_out1;
    send(2, 4); send(5, 4); send(1, 30);
    phase_checks("R8", b0, b1, 3);

    // R9: destination faster than source (3.4 ns period)
    cur_req = "R9";
    dhalf = 1.7;
    idle(10);
    b0 = n_out0; b1 = n_out1;
    for (int i = 0; i < 5; i++) send(1 + 2 * (i % 2), 2);
    send(12, 30);
    phase_checks("R9", b0, b1, 6);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule